// File: doc/BRIEF.md
# Paired Doubleword Load/Store Sequencer

This block runs 64-bit register-pair loads and stores on a 32-bit core that has only a word-wide data port. Decode hands it one operation at a time: direction, base value, offset, offset form (full or short) and the even register index of the pair. It computes the effective address and checks it. It then makes two word accesses to memory. For a load it writes both registers in one cycle. For a store it drives the two source words out in turn.

If any access faults, the sequence stops and the block reports a trap with the faulting word address. The core must issue the whole operation again once the handler returns. A word already stored may therefore be written twice. A misaligned address or an odd register index traps before any memory access takes place.

Register zero has its own rules. A store from the zero pair sends two zero words and reads no register. A load into the zero pair still makes both reads, then drops the data.

Top module: `dwpair_seq`

## Requirements
- R1: A successful load with a nonzero even index writes the pair in one single-cycle `rf_we` pulse, with `rf_waddr` set to the index. `rf_wdata_lo` is the word read at EA and `rf_wdata_hi` is the word read at EA+4. This pulse comes only after both responses have arrived.
- R2: The effective address (EA) has two forms. In the full form (`req_short`=0) it is base plus the 12-bit offset, sign-extended. In the short form (`req_short`=1) it is base plus the low 6 offset bits, zero-extended and multiplied by 8; the upper offset bits are ignored in that form.
- R3: An aligned operation makes exactly two word accesses. The first goes to EA and the second to EA+4. While `mem_req_ready` is low, the request and its address stay stable.
- R4: A store with a nonzero even index m writes register m to EA and register m+1 to EA+4.
- R5: A store with index 0 writes zero to both words. It asserts neither `rf_re0` nor `rf_re1`, so register 1 is never read.
- R6: A load with index 0 makes both memory reads, produces no `rf_we` pulse, and still completes with `done`.
- R7: A fault response on either access ends the sequence.
  - The block raises `trap_valid` with cause 2 and `trap_addr` equal to that word's address.
  - It makes no further access and no register write.
  - A first store word that was already written stays written.
- R8: An EA with bits [1:0] not zero traps with cause 1 and `trap_addr`=EA. No memory access is made.
- R9: An odd register index traps with cause 3 (illegal) and `trap_addr`=EA. No memory access is made. This check wins over the misalignment check.
- R10: `busy` rises on the edge that accepts a request (`req_valid` while `req_ready`) and stays high through the `done` or trap cycle. `req_ready` is low while busy, and requests presented then are ignored.
- R11: `done` and `trap_valid` are each single-cycle pulses and are never high together.
- R12: After reset the block is idle. `busy`, `done`, `trap_valid`, `rf_we` and `mem_req_valid` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_store | input | 1 | 1 = store pair, 0 = load pair |
| req_short | input | 1 | 1 = short offset form (zero-extended, scaled by 8) |
| req_base | input | AW | Base register value |
| req_off | input | OFF_W | Offset field |
| req_reg | input | RIDX_W | Even index of the register pair |
| rf_raddr0 | output | RIDX_W | Register read address, low word |
| rf_raddr1 | output | RIDX_W | Register read address, high word |
| rf_re0 | output | 1 | Read enable, low word |
| rf_re1 | output | 1 | Read enable, high word |
| rf_rdata0 | input | DW | Read data, low word |
| rf_rdata1 | input | DW | Read data, high word |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Access is a write |
| mem_req_addr | output | AW | Word address of the access |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_rdata | input | DW | Read data |
| mem_rsp_fault | input | 1 | Access faulted |
| rf_we | output | 1 | Pair write enable |
| rf_waddr | output | RIDX_W | Pair write index (low register) |
| rf_wdata_lo | output | DW | Data for the indexed register |
| rf_wdata_hi | output | DW | Data for the next register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Successful completion pulse |
| trap_valid | output | 1 | Trap pulse |
| trap_cause | output | 2 | 1 misaligned, 2 access fault, 3 illegal index |
| trap_addr | output | AW | Faulting address |

## Verification
The hardest case to reach is a store whose first word lands and whose second word faults, followed by a clean re-issue that writes the first word again. The bench memory model faults on one selected word address. It runs the store with the fault armed at EA+4, checks that the low word is already in memory and the high word is not, then disarms the fault and issues the same store again. The bench also stalls `mem_req_ready` on alternate table rows, and it changes the request lines while the block is busy, to show that only the accepted operation takes effect.

// File: rtl/dwpair_pkg.sv
package dwpair_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE     = 2'd0,
      CAUSE_MISALIGN = 2'd1,
      CAUSE_FAULT    = 2'd2,
      CAUSE_ILLEGAL  = 2'd3
   } cause_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE0,
      ST_WAIT0,
      ST_ISSUE1,
      ST_WAIT1,
      ST_COMMIT,
      ST_TRAP
   } state_e;

endpackage

// File: rtl/dwpair_agen.sv
module dwpair_agen #(
   parameter int AW      = 32,
   parameter int OFF_W   = 12,
   parameter int COFF_W  = 6,
   parameter int RIDX_W  = 5,
   parameter int ALIGN_B = 2,
   parameter bit CMP_EN  = 1'b1
) (
   input  logic [AW-1:0]     base_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic              short_i,
   input  logic [RIDX_W-1:0] ridx_i,
   output logic [AW-1:0]     ea_o,
   output logic              misal_o,
   output logic              illegal_o
);
   localparam int SCALE_SH = 3;

   generate
      if (OFF_W >= AW) begin : g_bad_off
         $error("dwpair_agen: OFF_W must be below AW");
      end
      if (COFF_W + SCALE_SH >= AW || COFF_W > OFF_W) begin : g_bad_coff
         $error("dwpair_agen: COFF_W out of range");
      end
   endgenerate

   logic [AW-1:0] off_full;
   assign off_full = {{(AW-OFF_W){off_i[OFF_W-1]}}, off_i};

   generate
      if (CMP_EN) begin : g_short
         logic [AW-1:0] off_short;
         assign off_short = {{(AW-COFF_W-SCALE_SH){1'b0}}, off_i[COFF_W-1:0], {SCALE_SH{1'b0}}};
         assign ea_o = base_i + (short_i ? off_short : off_full);
      end else begin : g_full_only
         logic unused_short;
         assign unused_short = short_i;
         assign ea_o = base_i + off_full;
      end
   endgenerate

   assign misal_o   = |ea_o[ALIGN_B-1:0];
   assign illegal_o = ridx_i[0];

endmodule

// File: rtl/dwpair_pairbuf.sv
module dwpair_pairbuf #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_src_i,
   input  logic          zero_src_i,
   input  logic [DW-1:0] src_lo_i,
   input  logic [DW-1:0] src_hi_i,
   input  logic          fill_i,
   input  logic          fill_hi_i,
   input  logic [DW-1:0] fill_data_i,
   output logic [DW-1:0] lo_o,
   output logic [DW-1:0] hi_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_o <= '0;
         hi_o <= '0;
      end else if (load_src_i) begin
         lo_o <= zero_src_i ? '0 : src_lo_i;
         hi_o <= zero_src_i ? '0 : src_hi_i;
      end else if (fill_i) begin
         if (fill_hi_i) hi_o <= fill_data_i;
         else           lo_o <= fill_data_i;
      end
   end

endmodule

// File: rtl/dwpair_ctrl.sv
module dwpair_ctrl
   import dwpair_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   input  logic   reject_i,
   input  logic   mem_rdy_i,
   input  logic   rsp_valid_i,
   input  logic   rsp_fault_i,
   output state_e state_o
);
   state_e nxt;

   always_comb begin
      nxt = state_o;
      unique case (state_o)
         ST_IDLE:   if (start_i) nxt = reject_i ? ST_TRAP : ST_ISSUE0;
         ST_ISSUE0: if (mem_rdy_i) nxt = ST_WAIT0;
         ST_WAIT0:  if (rsp_valid_i) nxt = rsp_fault_i ? ST_TRAP : ST_ISSUE1;
         ST_ISSUE1: if (mem_rdy_i) nxt = ST_WAIT1;
         ST_WAIT1:  if (rsp_valid_i) nxt = rsp_fault_i ? ST_TRAP : ST_COMMIT;
         ST_COMMIT: nxt = ST_IDLE;
         ST_TRAP:   nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= ST_IDLE;
      else        state_o <= nxt;
   end

endmodule

// File: rtl/dwpair_seq.sv
module dwpair_seq
   import dwpair_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int RIDX_W      = 5,
   parameter int OFF_W       = 12,
   parameter int COFF_W      = 6,
   parameter bit CMP_EN      = 1'b1,
   parameter bit LOWER_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_store,
   input  logic              req_short,
   input  logic [AW-1:0]     req_base,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [RIDX_W-1:0] req_reg,
   output logic [RIDX_W-1:0] rf_raddr0,
   output logic [RIDX_W-1:0] rf_raddr1,
   output logic              rf_re0,
   output logic              rf_re1,
   input  logic [DW-1:0]     rf_rdata0,
   input  logic [DW-1:0]     rf_rdata1,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [AW-1:0]     mem_req_addr,
   output logic [DW-1:0]     mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DW-1:0]     mem_rsp_rdata,
   input  logic              mem_rsp_fault,
   output logic              rf_we,
   output logic [RIDX_W-1:0] rf_waddr,
   output logic [DW-1:0]     rf_wdata_lo,
   output logic [DW-1:0]     rf_wdata_hi,
   output logic              busy,
   output logic              done,
   output logic              trap_valid,
   output logic [1:0]        trap_cause,
   output logic [AW-1:0]     trap_addr
);
   localparam int          WBYTES  = DW / 8;
   localparam int          ALIGN_B = $clog2(WBYTES);
   localparam logic [AW-1:0] STEP  = AW'(WBYTES);

   generate
      if (DW != 32 && DW != 64) begin : g_bad_dw
         $error("dwpair_seq: DW must be 32 or 64");
      end
      if (RIDX_W < 2) begin : g_bad_ridx
         $error("dwpair_seq: RIDX_W too small for register pairs");
      end
      if (AW <= ALIGN_B + 1) begin : g_bad_aw
         $error("dwpair_seq: AW too small");
      end
   endgenerate

   // Address generation and request checks
   logic [AW-1:0] ea;
   logic          ea_misal;
   logic          reg_odd;

   dwpair_agen #(
      .AW      (AW),
      .OFF_W   (OFF_W),
      .COFF_W  (COFF_W),
      .RIDX_W  (RIDX_W),
      .ALIGN_B (ALIGN_B),
      .CMP_EN  (CMP_EN)
   ) u_agen (
      .base_i    (req_base),
      .off_i     (req_off),
      .short_i   (req_short),
      .ridx_i    (req_reg),
      .ea_o      (ea),
      .misal_o   (ea_misal),
      .illegal_o (reg_odd)
   );

   // Sequencing
   state_e state;
   logic   accept;
   logic   reject;

   assign busy      = (state != ST_IDLE);
   assign req_ready = ~busy;
   assign accept    = req_valid & req_ready;
   assign reject    = reg_odd | ea_misal;

   dwpair_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (accept),
      .reject_i    (reject),
      .mem_rdy_i   (mem_req_ready),
      .rsp_valid_i (mem_rsp_valid),
      .rsp_fault_i (mem_rsp_fault),
      .state_o     (state)
   );

   // Captured operation
   logic              op_store;
   logic [RIDX_W-1:0] op_reg;
   logic [AW-1:0]     op_ea;
   cause_e            cause_q;
   logic [AW-1:0]     taddr_q;

   logic second;
   logic acc_hi;
   logic waiting;
   logic [AW-1:0] cur_addr;

   assign second  = (state == ST_ISSUE1) | (state == ST_WAIT1);
   assign waiting = (state == ST_WAIT0) | (state == ST_WAIT1);

   generate
      if (LOWER_FIRST) begin : g_low_first
         assign acc_hi = second;
      end else begin : g_high_first
         assign acc_hi = ~second;
      end
   endgenerate

   assign cur_addr = acc_hi ? (op_ea + STEP) : op_ea;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_store <= 1'b0;
         op_reg   <= '0;
         op_ea    <= '0;
         cause_q  <= CAUSE_NONE;
         taddr_q  <= '0;
      end else if (accept) begin
         op_store <= req_store;
         op_reg   <= req_reg;
         op_ea    <= ea;
         taddr_q  <= ea;
         if (reg_odd)       cause_q <= CAUSE_ILLEGAL;
         else if (ea_misal) cause_q <= CAUSE_MISALIGN;
         else               cause_q <= CAUSE_NONE;
      end else if (waiting && mem_rsp_valid && mem_rsp_fault) begin
         cause_q <= CAUSE_FAULT;
         taddr_q <= cur_addr;
      end
   end

   // Register-file read side (store source)
   logic src_take;
   logic src_zero;

   assign src_zero  = (req_reg == '0);
   assign src_take  = accept & req_store & ~reject;
   assign rf_raddr0 = req_reg;
   assign rf_raddr1 = {req_reg[RIDX_W-1:1], 1'b1};
   assign rf_re0    = src_take & ~src_zero;
   assign rf_re1    = src_take & ~src_zero;

   // Pair buffer: store source or load collection
   logic [DW-1:0] buf_lo;
   logic [DW-1:0] buf_hi;
   logic          fill;

   assign fill = waiting & mem_rsp_valid & ~mem_rsp_fault & ~op_store;

   dwpair_pairbuf #(
      .DW (DW)
   ) u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_src_i  (src_take),
      .zero_src_i  (src_zero),
      .src_lo_i    (rf_rdata0),
      .src_hi_i    (rf_rdata1),
      .fill_i      (fill),
      .fill_hi_i   (acc_hi),
      .fill_data_i (mem_rsp_rdata),
      .lo_o        (buf_lo),
      .hi_o        (buf_hi)
   );

   // Memory side
   assign mem_req_valid = (state == ST_ISSUE0) | (state == ST_ISSUE1);
   assign mem_req_we    = op_store;
   assign mem_req_addr  = cur_addr;
   assign mem_req_wdata = acc_hi ? buf_hi : buf_lo;

   // Commit and trap
   assign done        = (state == ST_COMMIT);
   assign rf_we       = done & ~op_store & (op_reg != '0);
   assign rf_waddr    = op_reg;
   assign rf_wdata_lo = buf_lo;
   assign rf_wdata_hi = buf_hi;
   assign trap_valid  = (state == ST_TRAP);
   assign trap_cause  = trap_valid ? cause_q : CAUSE_NONE;
   assign trap_addr   = taddr_q;

endmodule

// File: rtl/dwpair_seq_chk.sv
module dwpair_seq_chk #(
   parameter int AW     = 32,
   parameter int RIDX_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              busy,
   input logic              done,
   input logic              trap_valid,
   input logic [1:0]        trap_cause,
   input logic [AW-1:0]     trap_addr,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [AW-1:0]     mem_req_addr,
   input logic              mem_rsp_valid,
   input logic              mem_rsp_fault,
   input logic              rf_we,
   input logic              rf_re0,
   input logic              rf_re1,
   input logic [RIDX_W-1:0] rf_raddr0
);
   // Accesses handed to memory since the last accepted operation
   logic [1:0]    acc_n;
   logic [AW-1:0] first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_n   <= '0;
         first_q <= '0;
      end else if (req_valid && req_ready) begin
         acc_n <= '0;
      end else if (mem_req_valid && mem_req_ready) begin
         if (acc_n == 2'd0) first_q <= mem_req_addr;
         if (acc_n != 2'd3) acc_n <= acc_n + 2'd1;
      end
   end

   assert_second_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && acc_n == 2'd1) |-> (mem_req_addr == first_q + AW'(4)));

   assert_two_accesses_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (acc_n < 2'd2));

   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_zero_src_noread_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_re0 || rf_re1) |-> (rf_raddr0 != '0));

   assert_fault_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && mem_rsp_fault) |=> (trap_valid && trap_cause == 2'd2));

   assert_misal_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_cause == 2'd1) |-> (trap_addr[1:0] != 2'b00));

   assert_early_trap_noacc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && (trap_cause == 2'd1 || trap_cause == 2'd3)) |-> (acc_n == 2'd0));

   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   assert_mem_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy);

   assert_end_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, trap_valid}));

   assert_pair_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (done && acc_n == 2'd2));

   assert_pair_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);

endmodule

bind dwpair_seq dwpair_seq_chk u_chk (.*);

// File: tb/dwpair_seq_tb.sv
module dwpair_seq_tb;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic        rst_n;
   logic        req_valid, req_ready, req_store, req_short;
   logic [31:0] req_base;
   logic [11:0] req_off;
   logic [4:0]  req_reg;
   logic [4:0]  rf_raddr0, rf_raddr1;
   logic        rf_re0, rf_re1;
   logic [31:0] rf_rdata0, rf_rdata1;
   logic        mem_req_valid, mem_req_ready, mem_req_we;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_rdata;
   logic        mem_rsp_fault;
   logic        rf_we;
   logic [4:0]  rf_waddr;
   logic [31:0] rf_wdata_lo, rf_wdata_hi;
   logic        busy, done, trap_valid;
   logic [1:0]  trap_cause;
   logic [31:0] trap_addr;

   dwpair_seq u_dut (.*);

   function automatic logic [31:0] regval(input logic [4:0] i);
      return {8'hA5, 3'b000, i, 8'h5A, 3'b000, i};
   endfunction

   assign rf_rdata0 = regval(rf_raddr0);
   assign rf_rdata1 = regval(rf_raddr1);

   // Memory model and monitors
   logic [31:0] mem [64];
   logic        fault_en;
   logic [31:0] fault_addr;
   logic [31:0] watch_addr;
   logic        stall;
   int          cyc;
   int          acc_cnt, wr_cnt, rfw_cnt, trap_cnt, x1_rd, done_cnt, watch_hits;
   logic [31:0] first_addr, last_taddr, last_lo, last_hi;
   logic [1:0]  last_cause;
   logic [4:0]  last_waddr;

   assign mem_req_ready = !stall || cyc[0];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_fault <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         if (acc_cnt == 0) first_addr = mem_req_addr;
         acc_cnt = acc_cnt + 1;
         mem_rsp_valid <= 1'b1;
         mem_rsp_rdata <= mem[mem_req_addr[7:2]];
         if (fault_en && mem_req_addr == fault_addr) begin
            mem_rsp_fault <= 1'b1;
         end else if (mem_req_we) begin
            mem[mem_req_addr[7:2]] = mem_req_wdata;
            wr_cnt = wr_cnt + 1;
            if (mem_req_addr == watch_addr) watch_hits = watch_hits + 1;
         end
      end
      if (rf_we) begin
         rfw_cnt = rfw_cnt + 1;
         last_waddr = rf_waddr;
         last_lo = rf_wdata_lo;
         last_hi = rf_wdata_hi;
      end
      if (trap_valid) begin
         trap_cnt = trap_cnt + 1;
         last_cause = trap_cause;
         last_taddr = trap_addr;
      end
      if (done) done_cnt = done_cnt + 1;
      if (rf_re1 && rf_raddr1 == 5'd1) x1_rd = x1_rd + 1;
   end

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_counts();
      acc_cnt = 0; wr_cnt = 0; rfw_cnt = 0; trap_cnt = 0; x1_rd = 0; done_cnt = 0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 80 && busy; k++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_op(input logic st, input logic sh, input logic [4:0] rg,
                         input logic [31:0] b, input logic [11:0] o);
      @(negedge clk);
      clear_counts();
      req_valid = 1'b1; req_store = st; req_short = sh;
      req_reg = rg; req_base = b; req_off = o;
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
   endtask

   typedef struct packed {
      logic        st;
      logic        sh;
      logic [4:0]  rg;
      logic [31:0] base;
      logic [11:0] off;
      logic [1:0]  cause;
      logic [31:0] ea;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{1'b0, 1'b0, 5'd4,  32'h10, 12'h008, 2'd0, 32'h18},
      '{1'b0, 1'b0, 5'd6,  32'h40, 12'hFFC, 2'd0, 32'h3C},
      '{1'b1, 1'b0, 5'd8,  32'h80, 12'h004, 2'd0, 32'h84},
      '{1'b1, 1'b1, 5'd10, 32'h20, 12'h003, 2'd0, 32'h38},
      '{1'b0, 1'b1, 5'd12, 32'h00, 12'hFC7, 2'd0, 32'h38},
      '{1'b0, 1'b0, 5'd0,  32'h10, 12'h000, 2'd0, 32'h10},
      '{1'b1, 1'b0, 5'd0,  32'h50, 12'h000, 2'd0, 32'h50},
      '{1'b0, 1'b0, 5'd5,  32'h10, 12'h000, 2'd3, 32'h10},
      '{1'b1, 1'b0, 5'd4,  32'h12, 12'h000, 2'd1, 32'h12},
      '{1'b0, 1'b0, 5'd3,  32'h11, 12'h000, 2'd3, 32'h11}
   };

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_short = 1'b0;
      req_base = '0; req_off = '0; req_reg = '0;
      fault_en = 1'b0; fault_addr = '0; watch_addr = 32'hFFFF_FFFF; stall = 1'b0;
      cyc = 0; watch_hits = 0; first_addr = '0; last_taddr = '0;
      last_lo = '0; last_hi = '0; last_cause = '0; last_waddr = '0;
      mem_rsp_rdata = '0;
      clear_counts();
      for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 + 32'(i * 4);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      chk("R12 busy", 64'(busy), 64'd0);
      chk("R12 req_ready", 64'(req_ready), 64'd1);
      chk("R12 mem_req_valid", 64'(mem_req_valid), 64'd0);
      chk("R12 idle outputs", {61'd0, trap_valid, done, rf_we}, 64'd0);

      // Table walk
      for (int i = 0; i < 10; i++) begin
         vec_t v;
         int w;
         logic [31:0] exp_lo, exp_hi;
         v = VEC[i];
         w = int'(v.ea[7:2]);
         exp_lo = mem[w];
         exp_hi = mem[(w + 1) % 64];
         stall = i[0];
         run_op(v.st, v.sh, v.rg, v.base, v.off);
         if (v.cause != 2'd0) begin
            string t;
            t = (v.cause == 2'd1) ? "R8" : "R9";
            chk({t, " trap count"}, 64'(trap_cnt), 64'd1);
            chk({t, " cause"}, 64'(last_cause), 64'(v.cause));
            chk({t, " trap addr"}, 64'(last_taddr), 64'(v.ea));
            chk({t, " no access"}, 64'(acc_cnt), 64'd0);
            chk({t, " no rf write"}, 64'(rfw_cnt), 64'd0);
         end else begin
            chk("R3 two accesses", 64'(acc_cnt), 64'd2);
            chk("R2 R3 first addr is EA", 64'(first_addr), 64'(v.ea));
            chk("R11 done once", 64'(done_cnt), 64'd1);
            chk("R11 no trap", 64'(trap_cnt), 64'd0);
            if (!v.st) begin
               if (v.rg != 5'd0) begin
                  chk("R1 one pair write", 64'(rfw_cnt), 64'd1);
                  chk("R1 write index", 64'(last_waddr), 64'(v.rg));
                  chk("R1 R2 pair data", {last_hi, last_lo}, {exp_hi, exp_lo});
               end else begin
                  chk("R6 x0 no write", 64'(rfw_cnt), 64'd0);
               end
            end else begin
               logic [31:0] slo, shi;
               slo = (v.rg == 5'd0) ? 32'd0 : regval(v.rg);
               shi = (v.rg == 5'd0) ? 32'd0 : regval(v.rg | 5'd1);
               chk(v.rg == 5'd0 ? "R5 low word zero" : "R4 low word", 64'(mem[w]), 64'(slo));
               chk(v.rg == 5'd0 ? "R5 high word zero" : "R4 high word", 64'(mem[(w + 1) % 64]), 64'(shi));
               chk("R4 two writes", 64'(wr_cnt), 64'd2);
               if (v.rg == 5'd0) chk("R5 x1 not read", 64'(x1_rd), 64'd0);
               chk("R4 no rf write", 64'(rfw_cnt), 64'd0);
            end
         end
      end
      stall = 1'b0;

      // R7: store faults on its second word, then is re-issued
      begin
         logic [31:0] old_hi;
         old_hi = mem[25];
         fault_en = 1'b1; fault_addr = 32'h64; watch_addr = 32'h60; watch_hits = 0;
         run_op(1'b1, 1'b0, 5'd14, 32'h60, 12'h000);
         chk("R7 trap count", 64'(trap_cnt), 64'd1);
         chk("R7 cause fault", 64'(last_cause), 64'd2);
         chk("R7 trap addr second word", 64'(last_taddr), 64'h64);
         chk("R7 first word visible", 64'(mem[24]), 64'(regval(5'd14)));
         chk("R7 second word untouched", 64'(mem[25]), 64'(old_hi));
         chk("R7 no done", 64'(done_cnt), 64'd0);
         fault_en = 1'b0;
         run_op(1'b1, 1'b0, 5'd14, 32'h60, 12'h000);
         chk("R7 reissue completes", 64'(done_cnt), 64'd1);
         chk("R7 reissue high word", 64'(mem[25]), 64'(regval(5'd15)));
         chk("R7 first word written twice", 64'(watch_hits), 64'd2);
      end

      // R7: load faults on its first word
      begin
         logic [31:0] old_hi;
         old_hi = mem[29];
         fault_en = 1'b1; fault_addr = 32'h70;
         run_op(1'b0, 1'b0, 5'd16, 32'h70, 12'h000);
         chk("R7 load trap addr", 64'(last_taddr), 64'h70);
         chk("R7 load cause", 64'(last_cause), 64'd2);
         chk("R7 load stops after fault", 64'(acc_cnt), 64'd1);
         chk("R7 load no rf write", 64'(rfw_cnt), 64'd0);
         chk("R7 load memory intact", 64'(mem[29]), 64'(old_hi));
         fault_en = 1'b0;
      end

      // R10: requests offered while busy are ignored
      begin
         logic [31:0] old_w;
         logic [31:0] e_lo, e_hi;
         old_w = mem[9];
         e_lo = mem[8];
         e_hi = mem[9];
         @(negedge clk);
         clear_counts();
         req_valid = 1'b1; req_store = 1'b0; req_short = 1'b0;
         req_reg = 5'd18; req_base = 32'h20; req_off = 12'h000;
         @(negedge clk);
         chk("R10 busy after accept", 64'(busy), 64'd1);
         chk("R10 not ready while busy", 64'(req_ready), 64'd0);
         req_store = 1'b1; req_reg = 5'd20; req_base = 32'h24;
         @(negedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         wait_idle();
         chk("R10 one write", 64'(rfw_cnt), 64'd1);
         chk("R10 write from first op", 64'(last_waddr), 64'd18);
         chk("R10 first op data", {last_hi, last_lo}, {e_hi, e_lo});
         chk("R10 intruder store absent", 64'(wr_cnt), 64'd0);
         chk("R10 memory untouched", 64'(mem[9]), 64'(old_w));
         chk("R10 idle at end", 64'(busy), 64'd0);
      end

      finish_run();
   end

endmodule